// File: doc/BRIEF.md
# Dual-width register ALU datapath

This block is the arithmetic and logic stage of a 64-bit register machine. Each operation is presented on one cycle with a start strobe. It carries a 4-bit operation code, a bit that picks between a register operand and a 32-bit immediate, a width bit (32-bit or 64-bit), a 16-bit modifier field, the destination register's current value and the source register value. One cycle later the block presents the new destination value with a valid strobe.

The modifier field selects the signed forms of divide and modulo and the source width of a sign-extending move. The block gives defined results for the awkward cases. Division by zero yields zero. Modulo by zero keeps the dividend, with 32-bit mode still clearing the upper half. The most negative dividend divided by minus one wraps back to itself. An encoding the block does not support raises a one-cycle illegal flag, and the output register keeps its previous value.

Top module: `dual_alu`

## Requirements
- R1: After reset, `result` is 0 and both `result_valid` and `illegal_op` are low.
- R2: A legal operation sampled with `start` high produces its value on `result` with `result_valid` high for exactly one cycle, on the cycle after the start edge. Without `start`, neither strobe rises.
- R3: Codes in 64-bit mode: 0x0 adds, 0x1 subtracts, 0x2 multiplies (low half kept), 0x4 ORs, 0x5 ANDs, 0xa XORs, 0xb moves the operand and 0x8 negates the destination. All wrap silently.
- R4: With `use_reg`=0 the operand is `imm`. In 64-bit mode `imm` is sign-extended to 64 bits before use, including for unsigned divide and modulo. In 32-bit mode its 32 bits are used as they are.
- R5: In 32-bit mode (`wide`=0) the operation uses the low 32 bits of both operands, and the result is zero-extended into bits 63:32.
- R6: Code 0x3 divides. `offset`=0 gives unsigned division and `offset`=1 gives signed division truncated toward zero. The most negative value divided by -1 returns the dividend.
- R7: Code 0x9 gives the remainder. `offset`=0 is unsigned and `offset`=1 is signed, computed as a - n*trunc(a/n), so its sign follows the dividend (-13 mod 3 = -1). The most negative value mod -1 gives 0.
- R8: Division (code 0x3, either sign) by a zero divisor gives 0.
- R9: Modulo by a zero divisor returns the destination unchanged in 64-bit mode. In 32-bit mode it returns the low 32 bits of the destination with bits 63:32 cleared.
- R10: Code 0x6 shifts left, 0x7 shifts right logically and 0xc shifts right arithmetically. The amount is the operand masked with 0x3F in 64-bit mode and 0x1F in 32-bit mode.
- R11: Code 0xb with `offset` 8, 16 or 32 and `use_reg`=1 sign-extends that many low bits of `src_val`. In 64-bit mode it extends to 64 bits. In 32-bit mode it extends to 32 bits and clears bits 63:32.
- R12: Any of the following is illegal: code 0xd, 0xe or 0xf; a divide or modulo `offset` other than 0 or 1; a move `offset` other than 0, 8, 16 or 32; a sign-extending move with `use_reg`=0; a negate with `use_reg`=1; a nonzero `offset` on any other code. An illegal operation pulses `illegal_op` for one cycle in place of `result_valid`, and `result` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation code |
| use_reg | input | 1 | 1: operand from `src_val`; 0: operand from `imm` |
| wide | input | 1 | 1: 64-bit mode; 0: 32-bit mode |
| offset | input | 16 | Modifier: signed select or sign-extend width |
| imm | input | 32 | Immediate operand |
| dst_val | input | 64 | Current destination register value |
| src_val | input | 64 | Source register value |
| result | output | 64 | New destination value |
| result_valid | output | 1 | `result` updated by a legal operation |
| illegal_op | output | 1 | Last started operation was unsupported |

## Verification
The assertions assume that the operation fields are meaningful only on a cycle where `start` is high, and that the same fields still describe that operation when they are sampled back with `$past` on the following cycle. They also assume that reset is held across at least one clock edge. The bench changes every input only on the falling edge and raises `start` for the full cycle of each operation, so each operation's fields are settled when the clock rises. Operands for the zero-divisor and extreme-value cases are chosen so that the low 32 bits and the full 64 bits disagree, which keeps the two widths distinguishable.

// File: rtl/dual_alu.sv
module dual_alu #(
  parameter int W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [3:0]       op_code,
  input  logic             use_reg,
  input  logic             wide,
  input  logic [15:0]      offset,
  input  logic [W/2-1:0]   imm,
  input  logic [W-1:0]     dst_val,
  input  logic [W-1:0]     src_val,
  output logic [W-1:0]     result,
  output logic             result_valid,
  output logic             illegal_op
);
  localparam int H  = W / 2;
  localparam int SW = $clog2(W);
  localparam int SH = $clog2(H);

  localparam logic [3:0] C_ADD = 4'h0, C_SUB = 4'h1, C_MUL = 4'h2, C_DIV = 4'h3,
                         C_OR  = 4'h4, C_AND = 4'h5, C_LSH = 4'h6, C_RSH = 4'h7,
                         C_NEG = 4'h8, C_MOD = 4'h9, C_XOR = 4'ha, C_MOV = 4'hb,
                         C_ASR = 4'hc;

  logic [W-1:0] opb;
  assign opb = use_reg ? src_val : {{H{imm[H-1]}}, imm};

  logic sgn, sx8, sx16, sx32;
  assign sgn  = (offset == 16'd1);
  assign sx8  = (offset == 16'd8);
  assign sx16 = (offset == 16'd16);
  assign sx32 = (offset == 16'd32);

  logic bad;
  always_comb begin
    case (op_code)
      C_DIV, C_MOD: bad = (offset > 16'd1);
      C_MOV:        bad = !(offset == 16'd0 || ((sx8 || sx16 || sx32) && use_reg));
      C_NEG:        bad = use_reg || (offset != 16'd0);
      C_ADD, C_SUB, C_MUL, C_OR, C_AND, C_LSH, C_RSH, C_XOR, C_ASR:
                    bad = (offset != 16'd0);
      default:      bad = 1'b1;
    endcase
  end

  // 64-bit datapath
  logic [W-1:0] wa, wb, wma, wmb, wq, wr, wsq, wsr, wdiv, wmod, wmov, res_w;
  assign wa   = dst_val;
  assign wb   = opb;
  assign wma  = (sgn && wa[W-1]) ? -wa : wa;
  assign wmb  = (sgn && wb[W-1]) ? -wb : wb;
  assign wq   = (wmb == '0) ? '0 : wma / wmb;
  assign wr   = (wmb == '0) ? '0 : wma % wmb;
  assign wsq  = (sgn && (wa[W-1] ^ wb[W-1])) ? -wq : wq;
  assign wsr  = (sgn && wa[W-1]) ? -wr : wr;
  assign wdiv = (wb == '0) ? '0 : wsq;
  assign wmod = (wb == '0) ? wa : wsr;
  assign wmov = sx8  ? {{(W-8){src_val[7]}},   src_val[7:0]}   :
                sx16 ? {{(W-16){src_val[15]}}, src_val[15:0]}  :
                sx32 ? {{(W-32){src_val[31]}}, src_val[31:0]}  : wb;

  always_comb begin
    case (op_code)
      C_ADD:   res_w = wa + wb;
      C_SUB:   res_w = wa - wb;
      C_MUL:   res_w = wa * wb;
      C_DIV:   res_w = wdiv;
      C_OR:    res_w = wa | wb;
      C_AND:   res_w = wa & wb;
      C_LSH:   res_w = wa << wb[SW-1:0];
      C_RSH:   res_w = wa >> wb[SW-1:0];
      C_NEG:   res_w = -wa;
      C_MOD:   res_w = wmod;
      C_XOR:   res_w = wa ^ wb;
      C_MOV:   res_w = wmov;
      C_ASR:   res_w = $unsigned($signed(wa) >>> wb[SW-1:0]);
      default: res_w = wa;
    endcase
  end

  // 32-bit datapath
  logic [H-1:0] na, nb, nma, nmb, nq, nr, nsq, nsr, ndiv, nmod, nmov, res_n;
  assign na   = dst_val[H-1:0];
  assign nb   = opb[H-1:0];
  assign nma  = (sgn && na[H-1]) ? -na : na;
  assign nmb  = (sgn && nb[H-1]) ? -nb : nb;
  assign nq   = (nmb == '0) ? '0 : nma / nmb;
  assign nr   = (nmb == '0) ? '0 : nma % nmb;
  assign nsq  = (sgn && (na[H-1] ^ nb[H-1])) ? -nq : nq;
  assign nsr  = (sgn && na[H-1]) ? -nr : nr;
  assign ndiv = (nb == '0) ? '0 : nsq;
  assign nmod = (nb == '0) ? na : nsr;
  assign nmov = sx8  ? {{(H-8){src_val[7]}},   src_val[7:0]}  :
                sx16 ? {{(H-16){src_val[15]}}, src_val[15:0]} : nb;

  always_comb begin
    case (op_code)
      C_ADD:   res_n = na + nb;
      C_SUB:   res_n = na - nb;
      C_MUL:   res_n = na * nb;
      C_DIV:   res_n = ndiv;
      C_OR:    res_n = na | nb;
      C_AND:   res_n = na & nb;
      C_LSH:   res_n = na << nb[SH-1:0];
      C_RSH:   res_n = na >> nb[SH-1:0];
      C_NEG:   res_n = -na;
      C_MOD:   res_n = nmod;
      C_XOR:   res_n = na ^ nb;
      C_MOV:   res_n = nmov;
      C_ASR:   res_n = $unsigned($signed(na) >>> nb[SH-1:0]);
      default: res_n = na;
    endcase
  end

  logic [W-1:0] next_res;
  assign next_res = wide ? res_w : {{H{1'b0}}, res_n};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result       <= '0;
      result_valid <= 1'b0;
      illegal_op   <= 1'b0;
    end else begin
      result_valid <= start && !bad;
      illegal_op   <= start && bad;
      if (start && !bad) result <= next_res;
    end
  end
endmodule

// File: rtl/dual_alu_chk.sv
module dual_alu_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [3:0]   op_code,
  input logic         use_reg,
  input logic         wide,
  input logic [W-1:0] src_val,
  input logic [W-1:0] result,
  input logic         result_valid,
  input logic         illegal_op
);
  AST_STROBE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid || illegal_op) |-> $past(start)); // R2
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(result_valid && illegal_op)); // R12
  AST_ILLEGAL_HOLDS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> $stable(result)); // R12
  AST_NARROW_ZERO_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && $past(!wide)) |-> (result[W-1:W/2] == '0)); // R5
  AST_DIV_ZERO_GIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && $past(op_code == 4'h3 && use_reg &&
      (wide ? (src_val == '0) : (src_val[W/2-1:0] == '0)))) |-> (result == '0)); // R8
endmodule

bind dual_alu dual_alu_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code), .use_reg(use_reg),
  .wide(wide), .src_val(src_val), .result(result), .result_valid(result_valid),
  .illegal_op(illegal_op)
);

// File: tb/dual_alu_tb_top.sv
`timescale 1ns/1ps
module dual_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  op_code = '0;
  logic        use_reg = 1'b0;
  logic        wide = 1'b0;
  logic [15:0] offset = '0;
  logic [31:0] imm = '0;
  logic [63:0] dst_val = '0;
  logic [63:0] src_val = '0;
  logic [63:0] result;
  logic        result_valid;
  logic        illegal_op;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  typedef struct { logic [63:0] res; bit ill; string tag; } exp_t;
  exp_t q[$];
  logic [63:0] last_res = '0;

  always #4 clk = ~clk;

  dual_alu dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code), .use_reg(use_reg),
    .wide(wide), .offset(offset), .imm(imm), .dst_val(dst_val), .src_val(src_val),
    .result(result), .result_valid(result_valid), .illegal_op(illegal_op)
  );

  task automatic issue(input logic [3:0] op, input bit rs, input bit w,
                       input logic [15:0] off, input logic [31:0] im,
                       input logic [63:0] d, input logic [63:0] s,
                       input logic [63:0] er, input bit ill, input string tag);
    exp_t e;
    op_code = op; use_reg = rs; wide = w; offset = off; imm = im;
    dst_val = d; src_val = s; start = 1'b1;
    e.ill = ill; e.tag = tag;
    e.res = ill ? last_res : er;
    if (!ill) last_res = er;
    q.push_back(e);
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && (result_valid || illegal_op)) begin
        n_tests++;
        if (q.size() == 0) begin
          n_fail++;
          $display("FAIL R2 unexpected strobe: valid=%0b illegal=%0b expected none",
                   result_valid, illegal_op);
        end else begin
          e = q.pop_front();
          if (result !== e.res || result_valid !== !e.ill || illegal_op !== e.ill) begin
            n_fail++;
            $display("FAIL %s: result=%h valid=%0b illegal=%0b expected result=%h valid=%0b illegal=%0b",
                     e.tag, result, result_valid, illegal_op, e.res, !e.ill, e.ill);
          end
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin : watchdog
    #200000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_tests++;
    if (result !== 64'd0 || result_valid !== 1'b0 || illegal_op !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: result=%h valid=%0b illegal=%0b expected 0 0 0",
               result, result_valid, illegal_op);
    end

    // R3 basic ops, 64-bit
    issue(4'h0, 1, 1, 0, 0, 64'd5, 64'd7, 64'd12, 0, "R3 add");
    issue(4'h1, 1, 1, 0, 0, 64'd3, 64'd5, 64'hFFFF_FFFF_FFFF_FFFE, 0, "R3 sub wrap");
    issue(4'h2, 1, 1, 0, 0, 64'h1_0000_0001, 64'd3, 64'h3_0000_0003, 0, "R3 mul");
    issue(4'h5, 1, 1, 0, 0, 64'hF0F0, 64'hFF00, 64'hF000, 0, "R3 and");
    issue(4'ha, 1, 1, 0, 0, 64'hFF, 64'h0F, 64'hF0, 0, "R3 xor");
    issue(4'h8, 0, 1, 0, 0, 64'd1, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R3 neg");
    // R5 32-bit zero extension
    issue(4'h1, 1, 0, 0, 0, 64'd3, 64'd5, 64'h0000_0000_FFFF_FFFE, 0, "R5 sub32");
    issue(4'h0, 1, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd0, 0, "R5 add32 wrap");
    issue(4'h2, 1, 0, 0, 0, 64'h10000, 64'h10000, 64'd0, 0, "R5 mul32");
    issue(4'hb, 1, 0, 0, 0, 64'd0, 64'h1234_5678_9ABC_DEF0, 64'h0000_0000_9ABC_DEF0, 0, "R5 mov32");
    // R4 immediate
    issue(4'h4, 0, 1, 0, 32'h8000_0000, 64'd1, 64'd0, 64'hFFFF_FFFF_8000_0001, 0, "R4 or imm64");
    issue(4'h4, 0, 0, 0, 32'h8000_0000, 64'd1, 64'd0, 64'h0000_0000_8000_0001, 0, "R4 or imm32");
    issue(4'hb, 0, 1, 0, 32'hFFFF_FFFF, 64'd0, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R4 mov imm64");
    issue(4'h3, 0, 1, 0, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 64'd1, 0, "R4 udiv imm sext");
    // R6 divide
    issue(4'h3, 1, 0, 0, 0, 64'd100, 64'd7, 64'd14, 0, "R6 udiv32");
    issue(4'h3, 1, 1, 1, 0, 64'hFFFF_FFFF_FFFF_FFF3, 64'd3, 64'hFFFF_FFFF_FFFF_FFFC, 0, "R6 sdiv64");
    issue(4'h3, 1, 0, 1, 0, 64'h0000_0000_FFFF_FFF3, 64'd3, 64'h0000_0000_FFFF_FFFC, 0, "R6 sdiv32");
    issue(4'h3, 1, 1, 1, 0, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 0, "R6 min/-1 64");
    issue(4'h3, 1, 0, 1, 0, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_8000_0000, 0, "R6 min/-1 32");
    // R7 modulo
    issue(4'h9, 1, 1, 1, 0, 64'hFFFF_FFFF_FFFF_FFF3, 64'd3, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R7 smod -13%3");
    issue(4'h9, 1, 1, 1, 0, 64'd13, 64'hFFFF_FFFF_FFFF_FFFD, 64'd1, 0, "R7 smod 13%-3");
    issue(4'h9, 1, 0, 1, 0, 64'h0000_0000_FFFF_FFF3, 64'd3, 64'h0000_0000_FFFF_FFFF, 0, "R7 smod32");
    issue(4'h9, 1, 1, 1, 0, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 0, "R7 min%-1");
    issue(4'h9, 1, 1, 0, 0, 64'd100, 64'd7, 64'd2, 0, "R7 umod");
    // R8 divide by zero
    issue(4'h3, 1, 1, 0, 0, 64'd55, 64'd0, 64'd0, 0, "R8 udiv64 by 0");
    issue(4'h3, 1, 0, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_0000_0000, 64'd0, 0, "R8 sdiv32 by 0");
    // R9 modulo by zero
    issue(4'h9, 1, 1, 0, 0, 64'hDEAD_BEEF_1234_5678, 64'd0, 64'hDEAD_BEEF_1234_5678, 0, "R9 umod64 by 0");
    issue(4'h9, 1, 0, 0, 0, 64'hDEAD_BEEF_1234_5678, 64'd0, 64'h0000_0000_1234_5678, 0, "R9 umod32 by 0");
    issue(4'h9, 1, 0, 1, 0, 64'hAAAA_BBBB_CCCC_DDDD, 64'hFFFF_FFFF_0000_0000, 64'h0000_0000_CCCC_DDDD, 0, "R9 smod32 by 0");
    // R10 shifts
    issue(4'h6, 1, 1, 0, 0, 64'd1, 64'd65, 64'd2, 0, "R10 lsh64 mask");
    issue(4'h6, 1, 0, 0, 0, 64'd1, 64'd33, 64'd2, 0, "R10 lsh32 mask");
    issue(4'h7, 0, 1, 0, 32'd63, 64'h8000_0000_0000_0000, 64'd0, 64'd1, 0, "R10 rsh64");
    issue(4'hc, 1, 1, 0, 0, 64'h8000_0000_0000_0000, 64'd4, 64'hF800_0000_0000_0000, 0, "R10 arsh64");
    issue(4'hc, 1, 0, 0, 0, 64'h0000_0000_8000_0000, 64'd36, 64'h0000_0000_F800_0000, 0, "R10 arsh32 mask");
    issue(4'h7, 1, 0, 0, 0, 64'hFFFF_FFFF_8000_0000, 64'd4, 64'h0000_0000_0800_0000, 0, "R10 rsh32");
    // R11 sign-extending move
    issue(4'hb, 1, 1, 8, 0, 64'd0, 64'h80, 64'hFFFF_FFFF_FFFF_FF80, 0, "R11 sx8 64");
    issue(4'hb, 1, 0, 16, 0, 64'd0, 64'h8001, 64'h0000_0000_FFFF_8001, 0, "R11 sx16 32");
    issue(4'hb, 1, 1, 32, 0, 64'd0, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_8000_0000, 0, "R11 sx32 64");
    issue(4'hb, 1, 0, 32, 0, 64'd0, 64'h0000_0001_8000_0000, 64'h0000_0000_8000_0000, 0, "R11 sx32 32");
    // R12 illegal encodings
    issue(4'hd, 1, 1, 0, 0, 64'd9, 64'd9, 64'd0, 1, "R12 code d");
    issue(4'hf, 1, 0, 0, 0, 64'd9, 64'd9, 64'd0, 1, "R12 code f");
    issue(4'h3, 1, 1, 2, 0, 64'd9, 64'd3, 64'd0, 1, "R12 div offset 2");
    issue(4'hb, 1, 1, 4, 0, 64'd9, 64'd3, 64'd0, 1, "R12 mov offset 4");
    issue(4'h0, 1, 1, 1, 0, 64'd9, 64'd3, 64'd0, 1, "R12 add offset 1");
    issue(4'hb, 0, 1, 8, 32'h80, 64'd9, 64'd3, 64'd0, 1, "R12 movsx imm");
    issue(4'h8, 1, 1, 0, 0, 64'd9, 64'd3, 64'd0, 1, "R12 neg reg");
    issue(4'h0, 1, 1, 0, 0, 64'd2, 64'd2, 64'd4, 0, "R2 legal after illegal");
    // R2: idle cycles must stay quiet
    repeat (4) @(negedge clk);
    n_tests++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL R2 outstanding results: %0d left, expected 0", q.size());
    end
    finish_run();
  end
endmodule